// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked design read and write a 32K x 8 asynchronous static RAM. The RAM has two chip selects, one active low and one active high, an active-low write strobe, and one shared data bus. The user side is a single request port with address, write data and a read/write flag. A ready signal says when a new request can be taken. Read results come back on a data port together with a one-cycle valid pulse.

All RAM timing is counted in clock cycles. The counts are fixed at elaboration from the speed-grade parameter and the clock period. Each nanosecond figure is rounded up to whole cycles, and one cycle of margin is added to every bus release window. The data bus is split into an output, an output enable and an input, so a pad or a bench model can rebuild the tristate bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, `ready` is 1 and the RAM is deselected (`mem_sel_n`=1, `mem_sel`=0). `mem_wstb_n` is 1, `mem_doe` is 0 and `rvalid` is 0.
- R2: A read request accepted at clock edge E0 keeps the RAM selected with `mem_wstb_n`=1 for RD cycles (RD = 5 at a 10 ns clock, fastest grade). The bus is sampled at edge E0+RD. `rdata` then holds the stored byte while `rvalid` is 1 for exactly one cycle.
- R3: A write request stores `wdata` at `addr`. The write interval is the time during which `mem_wstb_n`=0, `mem_sel_n`=0 and `mem_sel`=1 all hold. It lasts WP cycles (WP = 5), which is at least the minimum write pulse and at least the write cycle time. The strobe is low only while the RAM is selected.
- R4: For a write, the address is presented one cycle before the write interval opens. It stays unchanged for the whole interval.
- R5: `mem_doe` is 1 only inside a write. It rises no earlier than REL cycles after the strobe falls (REL = 3, the 15 ns release time plus one cycle of margin). It stays on until one cycle after the interval closes, so the data is driven for at least the 20 ns setup time before the end.
- R6: The data bus is never driven while the RAM itself can drive it (selected with the strobe high). After a read, the RAM is kept deselected for REL cycles before `ready` returns.
- R7: `ready` is 0 from the edge after acceptance until the access ends. This is RD+REL cycles for a read and WP+2 cycles for a write. A request made while `ready` is 0 is ignored: it writes nothing and returns no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when `ready` is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Word address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, request can be taken |
| rvalid | output | 1 | One-cycle pulse: `rdata` holds a read result |
| rdata | output | 8 | Read data |
| mem_addr | output | 15 | RAM address |
| mem_sel_n | output | 1 | RAM chip select, active low |
| mem_sel | output | 1 | RAM chip select, active high |
| mem_wstb_n | output | 1 | RAM write strobe, active low |
| mem_dout | output | 8 | Data driven toward the RAM |
| mem_doe | output | 1 | Output enable for `mem_dout` |
| mem_din | input | 8 | Data bus as seen from the RAM |

## Verification
The tests use a RAM model whose read data is garbage until the access time has passed. This separates a correct access window from one that samples too early. The model also checks, on every write, the strobe length, when the bus drive starts, how long the address stays stable, and whether the bus is contended.

Several data patterns are used:
- alternating 55/AA bytes, which catch stuck or swapped data bits;
- the lowest and highest addresses, which catch truncated address bits;
- overwrites of the same address, which show that the last write is kept.

A request made while the controller is busy shows whether requests are accepted only when idle. A later read of the target address shows that this request left the RAM unchanged.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int GRADE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wstb_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int T_CYC = (GRADE == 0) ? 45 : (GRADE == 1) ? 55 : 70;
  localparam int T_WP  = (GRADE == 0) ? 35 : (GRADE == 1) ? 40 : 50;
  localparam int T_DSU = (GRADE == 0) ? 20 : (GRADE == 1) ? 25 : 30;
  localparam int T_REL = (GRADE == 0) ? 15 : (GRADE == 1) ? 20 : 25;

  localparam int RD_CYC  = (T_CYC + CLK_NS - 1) / CLK_NS;
  localparam int REL_CYC = (T_REL + CLK_NS - 1) / CLK_NS + 1;
  localparam int DSU_CYC = (T_DSU + CLK_NS - 1) / CLK_NS;
  localparam int WPM_CYC = (T_WP + CLK_NS - 1) / CLK_NS;
  localparam int WP_A    = (WPM_CYC > REL_CYC + DSU_CYC) ? WPM_CYC : REL_CYC + DSU_CYC;
  localparam int WP_CYC  = (WP_A > RD_CYC) ? WP_A : RD_CYC;
  localparam int CW      = $clog2(WP_CYC + RD_CYC + REL_CYC + 1);

  typedef enum logic [2:0] {IDLE, SETUP, WSTB, WEND, RACC, RREL} state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      rvalid   <= 1'b0;
      rdata    <= '0;
      mem_addr <= '0;
      mem_dout <= '0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        IDLE: if (req) begin
          mem_addr <= addr;
          cnt      <= '0;
          if (wr) begin
            mem_dout <= wdata;
            state    <= SETUP;
          end else begin
            state <= RACC;
          end
        end
        SETUP: begin
          cnt   <= '0;
          state <= WSTB;
        end
        WSTB: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WP_CYC - 1)) state <= WEND;
        end
        WEND: state <= IDLE;
        RACC: begin
          if (cnt == CW'(RD_CYC - 1)) begin
            rdata  <= mem_din;
            rvalid <= 1'b1;
            cnt    <= '0;
            state  <= RREL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RREL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(REL_CYC - 1)) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic selected;
  assign selected   = (state == WSTB) || (state == RACC);
  assign ready      = (state == IDLE);
  assign mem_sel_n  = !selected;
  assign mem_sel    = selected;
  assign mem_wstb_n = (state != WSTB);
  assign mem_doe    = ((state == WSTB) && (cnt >= CW'(REL_CYC))) || (state == WEND);

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_wstb_n,
  input logic              mem_doe
);

  p_idle_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_sel_n && !mem_sel && mem_wstb_n && !mem_doe));

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  p_strobe_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wstb_n |-> (!mem_sel_n && mem_sel));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wstb_n |-> $stable(mem_addr));

  p_drive_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_doe) |-> (!mem_wstb_n && $past(!mem_wstb_n)));

  p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> !(!mem_sel_n && mem_sel && mem_wstb_n));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int RD  = 5;
  localparam int REL = 3;
  localparam int WP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, rvalid, mem_sel_n, mem_sel, mem_wstb_n, mem_doe;
  logic [7:0]  rdata, mem_dout, mem_din;
  logic [14:0] mem_addr;

  always #5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wstb_n(mem_wstb_n),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din));

  int vectors = 0, errors = 0, cyc = 0;
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  int         cyc_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // RAM model
  int  age = 0;
  logic rd_on;
  assign rd_on = !mem_sel_n && mem_sel && mem_wstb_n;
  assign mem_din = !rd_on ? 8'hzz :
                   (age >= RD - 1) ? (ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00) : 8'hEE;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    age <= rd_on ? age + 1 : 0;
  end

  bit          wr_prev = 0, last_oe = 0;
  int          wlen = 0, oe_len = 0, pre_oe = 0;
  logic [7:0]  last_d;
  logic [14:0] w_addr, prev_addr;
  always @(negedge clk) if (rst_n) begin
    automatic bit wr_now = !mem_sel_n && mem_sel && !mem_wstb_n;
    if (mem_doe && rd_on) chk(0, "R6 bus contention", 1, 0);
    if (wr_now) begin
      if (!wr_prev) begin
        chk(mem_addr == prev_addr, "R4 address setup", mem_addr, prev_addr);
        w_addr = mem_addr; wlen = 0; oe_len = 0; pre_oe = 0;
      end
      if (mem_addr != w_addr) chk(0, "R4 address stable", mem_addr, w_addr);
      wlen++;
      if (mem_doe) oe_len++;
      else if (oe_len == 0) pre_oe++;
      last_d = mem_dout; last_oe = mem_doe;
    end else if (wr_prev) begin
      chk(last_oe && mem_doe, "R5 drive held to end", mem_doe, 1);
      chk(wlen * 10 >= 35 && wlen == WP, "R3 strobe width", wlen, WP);
      chk(pre_oe >= 2, "R5 drive after release", pre_oe, 2);
      chk(oe_len * 10 >= 20, "R5 data setup", oe_len * 10, 20);
      ram[int'(w_addr)] = last_d;
    end
    if (!wr_now && !mem_wstb_n) chk(0, "R3 strobe without select", 1, 0);
    wr_prev = wr_now;
    prev_addr = mem_addr;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rvalid) begin
    if (exp_q.size() == 0) chk(0, "R7 unexpected rvalid", rdata, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic int ec = cyc_q.pop_front();
      chk(rdata == e, "R2 read data", rdata, e);
      chk(cyc == ec, "R2 read latency", cyc, ec);
    end
  end

  task automatic access(input bit w, input logic [14:0] a, input logic [7:0] d, input bit busy_poke);
    int start;
    while (!ready) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    start = cyc;
    if (w) shadow[int'(a)] = d;
    else begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
      cyc_q.push_back(start + 1 + RD);
    end
    @(negedge clk);
    req = 0;
    chk(ready == 0, "R7 busy after accept", ready, 0);
    if (busy_poke) begin
      req = 1; wr = 1; addr = 15'h0123; wdata = 8'hC3;
      @(negedge clk); @(negedge clk);
      req = 0;
    end
    while (!ready) @(negedge clk);
    chk(cyc - start == (w ? WP + 3 : RD + REL + 1), "R7 busy length",
        cyc - start, w ? WP + 3 : RD + REL + 1);
    chk(mem_sel_n && !mem_sel && mem_wstb_n && !mem_doe, "R1 idle deselect",
        {mem_sel_n, mem_sel, mem_wstb_n, mem_doe}, 4'b1010);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && mem_sel_n && !mem_sel && mem_wstb_n && !mem_doe && !rvalid,
        "R1 reset state", {ready, mem_sel_n, mem_sel, mem_wstb_n, mem_doe, rvalid}, 6'b110100);
    rst_n = 1;
    @(negedge clk);
    access(1, 15'h0000, 8'h55, 0);
    access(1, 15'h7FFF, 8'hAA, 0);
    access(1, 15'h0123, 8'h3C, 0);
    access(0, 15'h0000, 8'h00, 0);
    access(0, 15'h7FFF, 8'h00, 0);
    for (int i = 0; i < 8; i++) access(1, 15'(1 << (i + 4)), 8'(i % 2 ? 8'hAA : 8'h55) ^ 8'(i), 0);
    for (int i = 0; i < 8; i++) access(0, 15'(1 << (i + 4)), 8'h00, 0);
    access(1, 15'h0000, 8'hFF, 0);
    access(1, 15'h0000, 8'h81, 0);
    access(0, 15'h0000, 8'h00, 0);
    access(0, 15'h7FFF, 8'h00, 1);   // R7: write poke while busy must be ignored
    access(0, 15'h0123, 8'h00, 0);
    access(0, 15'h0000, 8'h00, 0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    finish_run();
  end
endmodule